// File: doc/BRIEF.md
# Accumulator ALU with Shared Adder and Logic Unit

This block computes the next value of an accumulator for a small 8-bit machine. It has no registers. It takes the current accumulator and an operand from the data bus, and it returns two things: the value the accumulator should load and a flag that shows whether that value is zero. The surrounding control unit stores both.

Transfer, add, subtract, increment and clear all use one adder. The control unit picks the adder's first operand (accumulator or zero), its second operand (bus, inverted bus or zero) and its carry input. For example, subtraction is the accumulator plus the inverted bus plus one, and a bus transfer is zero plus the bus plus zero.

A separate logic unit computes AND, OR, XOR with the bus, or the complement of the accumulator. A final select chooses either the adder path or the logic path.

Top module: `acc_alu`

## Requirements
- R1: `opa_sel_i`=1 makes the adder's first operand the accumulator. `opa_sel_i`=0 makes it zero.
- R2: `opb_sel_i` sets the adder's second operand: 2'b00 gives zero, 2'b01 gives the bus, 2'b10 gives the bitwise inverse of the bus, and 2'b11 gives zero.
- R3: When `path_sel_i`=0, the result is first operand + second operand + `carry_i`, taken modulo 256. The carry out of the top bit is dropped.
- R4: Transfer (`opa_sel_i`=0, `opb_sel_i`=01, `carry_i`=0) returns the bus value unchanged.
- R5: Add (`opa_sel_i`=1, `opb_sel_i`=01, `carry_i`=0) returns the accumulator plus the bus modulo 256, so FFh + 01h gives 00h.
- R6: Subtract (`opa_sel_i`=1, `opb_sel_i`=10, `carry_i`=1) returns the accumulator minus the bus modulo 256, so 00h - 01h gives FFh.
- R7: Increment (`opa_sel_i`=1, `opb_sel_i`=00, `carry_i`=1) returns the accumulator plus one modulo 256, so FFh gives 00h.
- R8: Clear (`opa_sel_i`=0, `opb_sel_i`=00, `carry_i`=0) returns 00h whatever the accumulator holds.
- R9: When `path_sel_i`=1, the result comes from the logic unit, with `logic_op_i` encoded as follows: 2'b00 gives acc AND bus, 2'b01 gives acc OR bus, 2'b10 gives acc XOR bus, and 2'b11 gives NOT acc.
- R10: `zero_o` is 1 exactly when `acc_next_o` is 00h.
- R11: When `path_sel_i`=1, the adder controls (`opa_sel_i`, `opb_sel_i`, `carry_i`) have no effect on `acc_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator value |
| bus_i | input | 8 | Operand from the data bus |
| opa_sel_i | input | 1 | Adder first operand: 1 = accumulator, 0 = zero |
| opb_sel_i | input | 2 | Adder second operand select |
| carry_i | input | 1 | Adder carry input |
| logic_op_i | input | 2 | Logic unit operation select |
| path_sel_i | input | 1 | Result select: 0 = adder, 1 = logic unit |
| acc_next_o | output | 8 | Value for the accumulator to load |
| zero_o | output | 1 | High when `acc_next_o` is zero |

## Verification
The bench targets the wrap boundaries, because a design that keeps the carry would be wrong there. Such a design would return 100h-style garbage or a nonzero flag for FFh+01h and for an increment of FFh. It would also get 00h-01h wrong if the inverted bus or the carry-in were mishandled.

Transfer and clear are checked with the accumulator at FFh. A design that leaked the accumulator into the adder would show it in the result.

With the logic path selected, every combination of adder controls is swept. Any leak from the adder into the result would show up as a change in the output.

The reserved second-operand code is also exercised. A decoder that treated it as the bus or the inverted bus would produce a wrong sum.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    OPB_ZERO = 2'b00,
    OPB_BUS  = 2'b01,
    OPB_INV  = 2'b10,
    OPB_RSVD = 2'b11
  } opb_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;
endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic             opa_sel_i,
  input  logic [1:0]       opb_sel_i,
  output logic [WIDTH-1:0] opa_o,
  output logic [WIDTH-1:0] opb_o
);
  import acc_alu_pkg::*;

  assign opa_o = opa_sel_i ? acc_i : '0;

  always_comb begin
    case (opb_e'(opb_sel_i))
      OPB_BUS: opb_o = bus_i;
      OPB_INV: opb_o = ~bus_i;
      default: opb_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int PADW = WIDTH - 1;

  // The carry out of the top bit is dropped, so the sum wraps.
  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y,
                                                input logic             c);
    return x + y + {{PADW{1'b0}}, c};
  endfunction

  assign sum_o = wrap_add(a_i, b_i, cin_i);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);
  import acc_alu_pkg::*;

  always_comb begin
    case (lop_e'(op_i))
      LOP_AND: res_o = acc_i & bus_i;
      LOP_OR:  res_o = acc_i | bus_i;
      LOP_XOR: res_o = acc_i ^ bus_i;
      default: res_o = ~acc_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic             opa_sel_i,
  input  logic [1:0]       opb_sel_i,
  input  logic             carry_i,
  input  logic [1:0]       logic_op_i,
  input  logic             path_sel_i,
  output logic [WIDTH-1:0] acc_next_o,
  output logic             zero_o
);
  // Named internal nodes, kept visible for the checker.
  logic [WIDTH-1:0] opa;
  logic [WIDTH-1:0] opb;
  logic [WIDTH-1:0] adder_sum;
  logic [WIDTH-1:0] logic_res;

  acc_alu_opsel #(.WIDTH(WIDTH)) u_opsel (
    .acc_i     (acc_i),
    .bus_i     (bus_i),
    .opa_sel_i (opa_sel_i),
    .opb_sel_i (opb_sel_i),
    .opa_o     (opa),
    .opb_o     (opb)
  );

  acc_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i   (opa),
    .b_i   (opb),
    .cin_i (carry_i),
    .sum_o (adder_sum)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .acc_i (acc_i),
    .bus_i (bus_i),
    .op_i  (logic_op_i),
    .res_o (logic_res)
  );

  assign acc_next_o = path_sel_i ? logic_res : adder_sum;
  assign zero_o     = ~|acc_next_o;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] bus_i,
  input logic             opa_sel_i,
  input logic [1:0]       opb_sel_i,
  input logic             carry_i,
  input logic [1:0]       logic_op_i,
  input logic             path_sel_i,
  input logic [WIDTH-1:0] acc_next_o,
  input logic             zero_o,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] adder_sum,
  input logic [WIDTH-1:0] logic_res
);
  logic known;
  assign known = !$isunknown({acc_i, bus_i, opa_sel_i, opb_sel_i, carry_i,
                              logic_op_i, path_sel_i});

  always_comb begin
    if (known) begin
      // R1
      opa_select_chk: assert (opa_sel_i ? (opa == acc_i) : (opa == '0));
      // R2
      opb_select_chk: assert ((opb_sel_i == 2'b01) ? (opb == bus_i) :
                              (opb_sel_i == 2'b10) ? ((opb ^ bus_i) == '1) :
                              (opb == '0));
      // R3
      arith_path_chk: assert (path_sel_i || (acc_next_o == adder_sum));
      // R6
      if (!path_sel_i && opa_sel_i && opb_sel_i == 2'b10 && carry_i)
        sub_inverse_chk: assert (WIDTH'(acc_next_o + bus_i) == acc_i);
      // R9
      logic_path_chk: assert (!path_sel_i || (acc_next_o == logic_res));
      // R10
      zero_flag_chk: assert (zero_o == (acc_next_o == '0));
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_acc_alu_chk (
  .acc_i      (acc_i),
  .bus_i      (bus_i),
  .opa_sel_i  (opa_sel_i),
  .opb_sel_i  (opb_sel_i),
  .carry_i    (carry_i),
  .logic_op_i (logic_op_i),
  .path_sel_i (path_sel_i),
  .acc_next_o (acc_next_o),
  .zero_o     (zero_o),
  .opa        (opa),
  .opb        (opb),
  .adder_sum  (adder_sum),
  .logic_res  (logic_res)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc = '0, bus = '0;
  logic       opa_sel = 1'b0, carry = 1'b0, path_sel = 1'b0;
  logic [1:0] opb_sel = '0, lop = '0;
  logic [7:0] acc_next;
  logic       zero;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .acc_i(acc), .bus_i(bus), .opa_sel_i(opa_sel), .opb_sel_i(opb_sel),
    .carry_i(carry), .logic_op_i(lop), .path_sel_i(path_sel),
    .acc_next_o(acc_next), .zero_o(zero)
  );

  // Reference model written from the requirements, using integer arithmetic.
  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic as, input logic [1:0] bs,
                                       input logic c, input logic [1:0] op,
                                       input logic ps);
    int x, y;
    if (ps) begin
      case (op)
        2'b00: return a & b;
        2'b01: return a | b;
        2'b10: return a ^ b;
        default: return 8'(255 - int'(a));
      endcase
    end
    x = as ? int'(a) : 0;
    y = (bs == 2'b01) ? int'(b) : (bs == 2'b10) ? 255 - int'(b) : 0;
    return 8'((x + y + int'(c)) % 256);
  endfunction

  task automatic apply(input string req, input logic [7:0] a, input logic [7:0] b,
                       input logic as, input logic [1:0] bs, input logic c,
                       input logic [1:0] op, input logic ps);
    logic [7:0] exp;
    @(posedge clk);
    acc = a; bus = b; opa_sel = as; opb_sel = bs; carry = c; lop = op; path_sel = ps;
    @(negedge clk);
    exp = model(a, b, as, bs, c, op, ps);
    checks++;
    if (acc_next !== exp) begin
      errors++;
      $display("FAIL %s: acc=%02h bus=%02h result actual=%02h expected=%02h",
               req, a, b, acc_next, exp);
    end
    checks++;
    if (zero !== (exp == 8'h00)) begin
      errors++;
      $display("FAIL R10 (%s): zero actual=%0b expected=%0b", req, zero, exp == 8'h00);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] ref_out;
    void'($urandom(32'h5EED_0A1C));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // All-zero inputs: clear result, zero flag set (R8, R10)
    apply("R8 initial", 8'h00, 8'h00, 0, 2'b00, 0, 2'b00, 0);
    // R1 / R2 operand selection
    apply("R1 opa zero", 8'hA5, 8'h00, 0, 2'b00, 1, 2'b00, 0);
    apply("R1 opa acc", 8'hA5, 8'h00, 1, 2'b00, 0, 2'b00, 0);
    apply("R2 opb reserved", 8'h10, 8'h3C, 1, 2'b11, 0, 2'b00, 0);
    apply("R2 opb inverse", 8'h00, 8'h3C, 0, 2'b10, 0, 2'b00, 0);
    // R4 transfer
    apply("R4 transfer 00", 8'hFF, 8'h00, 0, 2'b01, 0, 2'b00, 0);
    apply("R4 transfer FF", 8'hFF, 8'hFF, 0, 2'b01, 0, 2'b00, 0);
    // R5 add, R3 wrap
    apply("R5 add", 8'h27, 8'h39, 1, 2'b01, 0, 2'b00, 0);
    apply("R5 R3 add wrap", 8'hFF, 8'h01, 1, 2'b01, 0, 2'b00, 0);
    apply("R3 add FF+FF+1", 8'hFF, 8'hFF, 1, 2'b01, 1, 2'b00, 0);
    // R6 subtract
    apply("R6 sub equal", 8'h05, 8'h05, 1, 2'b10, 1, 2'b00, 0);
    apply("R6 sub borrow", 8'h00, 8'h01, 1, 2'b10, 1, 2'b00, 0);
    apply("R6 sub FF", 8'h00, 8'hFF, 1, 2'b10, 1, 2'b00, 0);
    // R7 increment
    apply("R7 inc wrap", 8'hFF, 8'h12, 1, 2'b00, 1, 2'b00, 0);
    apply("R7 inc 7F", 8'h7F, 8'h12, 1, 2'b00, 1, 2'b00, 0);
    // R8 clear
    apply("R8 clear FF", 8'hFF, 8'hFF, 0, 2'b00, 0, 2'b00, 0);
    // R9 logic ops on corners
    for (int op = 0; op < 4; op++) begin
      apply("R9 logic FF/00", 8'hFF, 8'h00, 0, 2'b00, 0, 2'(op), 1);
      apply("R9 logic 00/FF", 8'h00, 8'hFF, 0, 2'b00, 0, 2'(op), 1);
      apply("R9 logic C3/5A", 8'hC3, 8'h5A, 0, 2'b00, 0, 2'(op), 1);
    end
    // R11 adder controls ignored on logic path
    ref_out = model(8'h6E, 8'hB1, 0, 2'b00, 0, 2'b10, 1);
    for (int k = 0; k < 16; k++) begin
      apply("R11 adder ctl ignored", 8'h6E, 8'hB1, k[0], k[2:1], k[3], 2'b10, 1);
      checks++;
      if (acc_next !== ref_out) begin
        errors++;
        $display("FAIL R11: actual=%02h expected=%02h", acc_next, ref_out);
      end
    end
    // Constrained random: named operations
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      if (i % 16 == 0) a = 8'hFF;
      if (i % 16 == 1) b = 8'h00;
      if (i % 16 == 2) b = 8'hFF;
      case ($urandom % 6)
        0: apply("R4 rand transfer", a, b, 0, 2'b01, 0, 2'b00, 0);
        1: apply("R5 rand add", a, b, 1, 2'b01, 0, 2'b00, 0);
        2: apply("R6 rand sub", a, b, 1, 2'b10, 1, 2'b00, 0);
        3: apply("R7 rand inc", a, b, 1, 2'b00, 1, 2'b00, 0);
        4: apply("R8 rand clear", a, b, 0, 2'b00, 0, 2'b00, 0);
        default: apply("R9 rand logic", a, b, 0, 2'b00, 0, 2'($urandom), 1);
      endcase
    end
    // Fully random controls
    for (int i = 0; i < 400; i++)
      apply("R3 rand controls", 8'($urandom), 8'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    finish_run();
  end
endmodule